// File: doc/BRIEF.md
# Filter coefficient block loader

This block sits between a register write path and a two-channel filter. Software sends 16-bit data words, each tagged with a register address. Two addresses are meaningful, and each one names a coefficient block. A block is a fixed-length run of writes to one address. Each write carries a single byte in bits [7:0] of the data word. Bits [15:8] are never used.

The channel 1 block carries six 8-bit coefficients. The channel 2 block is longer. It starts with three bytes that pack two 12-bit DC offset constants on a nibble boundary, and ends with six 8-bit channel 2 coefficients. Bytes collect in a shadow set. They reach the active outputs in one step, at the moment the last byte of the block arrives. No separate load command is needed.

A block that is interrupted by a write to the other block address is abandoned. Counting restarts for the newly addressed block, and the active values are left as they were. A one-cycle commit pulse per channel tells the filter that its active values have just changed.

Top module: `coef_block_loader`

## Requirements
- R1: After reset, all active coefficients and both offsets read zero, both commit pulses are low, and no block is in progress: the next write to a block address counts as its first byte. A reset in the middle of a block discards that block.
- R2: Only bits [7:0] of `wr_data` are used. The value of bits [15:8] has no effect on any output.
- R3: Channel 1 block: exactly 6 writes to address 0x0001. They carry coefficients 5, 4, 3, 2, 1, 0, in that order. Coefficient k appears on `ch1_coefs_o[8k+7:8k]`.
- R4: Channel 2 block: exactly 9 writes to address 0x0005. Writes 4 to 9 carry channel 2 coefficients 5 down to 0. Coefficient k appears on `ch2_coefs_o[8k+7:8k]`.
- R5: In the channel 2 block, write 1 gives offset A bits [7:0]. Write 2 gives offset A bits [11:8] in its low nibble and offset B bits [3:0] in its high nibble. Write 3 gives offset B bits [11:4]. Offset A goes to `ch1_ofs_o` and offset B to `ch2_ofs_o`, both at the completion of the channel 2 block. For example, the bytes 0x04, 0x40, 0x00 yield 0x004 for both offsets.
- R6: The active outputs of a channel do not change until its block completes. They update on the clock edge that captures the last byte, so the new values are visible in the following cycle.
- R7: Commit pulses last one cycle and coincide with the output update. Completing a channel 1 block raises `ch1_commit_o` only. Completing a channel 2 block raises both `ch1_commit_o` and `ch2_commit_o`, because offset A belongs to channel 1.
- R8: A write to the other block address before the current block completes has three effects. The partial block is discarded. The new write counts as byte 1 of the newly addressed block. Neither active set changes.
- R9: Cycles with `wr_en` low, and writes to any address other than 0x0001 or 0x0005, cause no commit and no change of outputs. They do not disturb a block in progress.
- R10: After a block completes, the next write to either block address starts a new block at byte 1. This allows blocks to be sent back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | 16 | Register address of the write |
| wr_data | input | 16 | Write data; byte in bits [7:0] |
| ch1_coefs_o | output | 48 | Active channel 1 coefficients, coefficient k at [8k+7:8k] |
| ch2_coefs_o | output | 48 | Active channel 2 coefficients, coefficient k at [8k+7:8k] |
| ch1_ofs_o | output | 12 | Active channel 1 DC offset |
| ch2_ofs_o | output | 12 | Active channel 2 DC offset |
| ch1_commit_o | output | 1 | One-cycle pulse: channel 1 active values updated |
| ch2_commit_o | output | 1 | One-cycle pulse: channel 2 active values updated |

## Verification
Every result of this block is due exactly one clock edge after the write that causes it. The commit pulses and the new active values both appear after the edge that captures the final byte of a block, and nothing changes on any other write. The bench drives each write just after a rising edge and samples the pulses and outputs one time unit after the next rising edge. As a result, every check observes the cycle in which the result is due. For intermediate writes of a block, the same sampling point confirms that no pulse has appeared and that the active values are still the old ones.

// File: rtl/coef_loader_pkg.sv
package coef_loader_pkg;

  // Transfer unit carried in the low part of every data word
  localparam int unsigned BYTE_W    = 8;
  // DC offset constants are 12 bits, two of them packed in three bytes
  localparam int unsigned OFS_W     = 12;
  localparam int unsigned OFS_BYTES = (2 * OFS_W) / BYTE_W;

  typedef enum logic {
    BLK_CH1 = 1'b0,
    BLK_CH2 = 1'b1
  } blk_e;

endpackage

// File: rtl/coef_rst_sync.sv
module coef_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;

endmodule

// File: rtl/coef_seq_ctrl.sv
module coef_seq_ctrl
  import coef_loader_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 16,
  parameter int unsigned          N_COEF   = 6,
  parameter logic [ADDR_W-1:0]    CH1_ADDR = 16'h0001,
  parameter logic [ADDR_W-1:0]    CH2_ADDR = 16'h0005,
  localparam int unsigned         LEN1     = N_COEF,
  localparam int unsigned         LEN2     = OFS_BYTES + N_COEF,
  localparam int unsigned         POS_W    = $clog2(LEN2 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              byte_we,
  output blk_e              byte_blk,
  output logic [POS_W-1:0]  byte_pos,
  output logic              byte_last
);

  logic             busy_q, busy_d;
  blk_e             blk_q, blk_d;
  logic [POS_W-1:0] pos_q, pos_d;

  logic             hit1, hit2, hit;
  blk_e             sel;
  logic [POS_W-1:0] cur;
  logic [POS_W-1:0] end_pos;
  logic             last;

  // Next-state logic: byte position within the addressed block
  always_comb begin
    hit1    = wr_en && (wr_addr == CH1_ADDR);
    hit2    = wr_en && (wr_addr == CH2_ADDR);
    hit     = hit1 || hit2;
    sel     = hit2 ? BLK_CH2 : BLK_CH1;
    // a write to the other block (or after completion) restarts at byte 1
    cur     = (busy_q && (blk_q == sel)) ? pos_q : '0;
    end_pos = (sel == BLK_CH2) ? POS_W'(LEN2 - 1) : POS_W'(LEN1 - 1);
    last    = (cur == end_pos);

    busy_d = busy_q;
    blk_d  = blk_q;
    pos_d  = pos_q;
    if (hit) begin
      if (last) begin
        busy_d = 1'b0;
        pos_d  = '0;
      end else begin
        busy_d = 1'b1;
        blk_d  = sel;
        pos_d  = cur + POS_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      blk_q  <= BLK_CH1;
      pos_q  <= '0;
    end else if (hit) begin
      busy_q <= busy_d;
      blk_q  <= blk_d;
      pos_q  <= pos_d;
    end
  end

  assign byte_we   = hit;
  assign byte_blk  = sel;
  assign byte_pos  = cur;
  assign byte_last = hit && last;

endmodule

// File: rtl/coef_shadow.sv
module coef_shadow
  import coef_loader_pkg::*;
#(
  parameter int unsigned  N_COEF = 6,
  localparam int unsigned LEN2   = OFS_BYTES + N_COEF,
  localparam int unsigned POS_W  = $clog2(LEN2 + 1),
  localparam int unsigned SET_W  = N_COEF * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_we,
  input  blk_e              byte_blk,
  input  logic [POS_W-1:0]  byte_pos,
  input  logic [BYTE_W-1:0] byte_val,
  output logic [SET_W-1:0]  c1_nxt,
  output logic [SET_W-1:0]  c2_nxt,
  output logic [OFS_W-1:0]  o1_nxt,
  output logic [OFS_W-1:0]  o2_nxt
);

  logic [SET_W-1:0] c1_q, c2_q;
  logic [OFS_W-1:0] o1_q, o2_q;

  logic we1, we2;
  assign we1 = byte_we && (byte_blk == BLK_CH1);
  assign we2 = byte_we && (byte_blk == BLK_CH2);

  // Coefficient slots: sent in descending index order
  for (genvar k = 0; k < N_COEF; k++) begin : g_slot
    localparam int unsigned P1 = N_COEF - 1 - k;
    localparam int unsigned P2 = OFS_BYTES + N_COEF - 1 - k;
    assign c1_nxt[k*BYTE_W +: BYTE_W] =
      (we1 && (byte_pos == POS_W'(P1))) ? byte_val : c1_q[k*BYTE_W +: BYTE_W];
    assign c2_nxt[k*BYTE_W +: BYTE_W] =
      (we2 && (byte_pos == POS_W'(P2))) ? byte_val : c2_q[k*BYTE_W +: BYTE_W];
  end

  // Offset unpacking: split on a nibble boundary in the middle byte
  always_comb begin
    o1_nxt = o1_q;
    o2_nxt = o2_q;
    if (we2) begin
      case (byte_pos)
        POS_W'(0): o1_nxt[7:0] = byte_val;
        POS_W'(1): begin
          o1_nxt[11:8] = byte_val[3:0];
          o2_nxt[3:0]  = byte_val[7:4];
        end
        POS_W'(2): o2_nxt[11:4] = byte_val;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1_q <= '0;
      c2_q <= '0;
      o1_q <= '0;
      o2_q <= '0;
    end else if (byte_we) begin
      c1_q <= c1_nxt;
      c2_q <= c2_nxt;
      o1_q <= o1_nxt;
      o2_q <= o2_nxt;
    end
  end

endmodule

// File: rtl/coef_active_bank.sv
module coef_active_bank
  import coef_loader_pkg::*;
#(
  parameter int unsigned  N_COEF = 6,
  localparam int unsigned SET_W  = N_COEF * BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit1,
  input  logic             commit2,
  input  logic [SET_W-1:0] c1_nxt,
  input  logic [SET_W-1:0] c2_nxt,
  input  logic [OFS_W-1:0] o1_nxt,
  input  logic [OFS_W-1:0] o2_nxt,
  output logic [SET_W-1:0] c1_act,
  output logic [SET_W-1:0] c2_act,
  output logic [OFS_W-1:0] o1_act,
  output logic [OFS_W-1:0] o2_act,
  output logic             pulse1,
  output logic             pulse2
);

  logic pulse1_d, pulse2_d;

  always_comb begin
    // channel 2 completion also carries channel 1's offset
    pulse1_d = commit1 || commit2;
    pulse2_d = commit2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse1 <= 1'b0;
      pulse2 <= 1'b0;
    end else begin
      pulse1 <= pulse1_d;
      pulse2 <= pulse2_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1_act <= '0;
    end else if (commit1) begin
      c1_act <= c1_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_act <= '0;
      o1_act <= '0;
      o2_act <= '0;
    end else if (commit2) begin
      c2_act <= c2_nxt;
      o1_act <= o1_nxt;
      o2_act <= o2_nxt;
    end
  end

endmodule

// File: rtl/coef_block_loader.sv
module coef_block_loader
  import coef_loader_pkg::*;
#(
  parameter int unsigned        ADDR_W   = 16,
  parameter int unsigned        DATA_W   = 16,
  parameter int unsigned        N_COEF   = 6,
  parameter logic [ADDR_W-1:0]  CH1_ADDR = 16'h0001,
  parameter logic [ADDR_W-1:0]  CH2_ADDR = 16'h0005,
  localparam int unsigned       LEN2     = OFS_BYTES + N_COEF,
  localparam int unsigned       POS_W    = $clog2(LEN2 + 1),
  localparam int unsigned       SET_W    = N_COEF * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SET_W-1:0]  ch1_coefs_o,
  output logic [SET_W-1:0]  ch2_coefs_o,
  output logic [OFS_W-1:0]  ch1_ofs_o,
  output logic [OFS_W-1:0]  ch2_ofs_o,
  output logic              ch1_commit_o,
  output logic              ch2_commit_o
);

  logic             srst_n;
  logic             byte_we;
  blk_e             byte_blk;
  logic [POS_W-1:0] byte_pos;
  logic             byte_last;
  logic [SET_W-1:0] c1_nxt, c2_nxt;
  logic [OFS_W-1:0] o1_nxt, o2_nxt;
  logic             commit1, commit2;

  // upper byte of the data word carries nothing
  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:BYTE_W];

  coef_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  coef_seq_ctrl #(
    .ADDR_W   (ADDR_W),
    .N_COEF   (N_COEF),
    .CH1_ADDR (CH1_ADDR),
    .CH2_ADDR (CH2_ADDR)
  ) u_seq (
    .clk       (clk),
    .rst_n     (srst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .byte_we   (byte_we),
    .byte_blk  (byte_blk),
    .byte_pos  (byte_pos),
    .byte_last (byte_last)
  );

  coef_shadow #(
    .N_COEF (N_COEF)
  ) u_shadow (
    .clk      (clk),
    .rst_n    (srst_n),
    .byte_we  (byte_we),
    .byte_blk (byte_blk),
    .byte_pos (byte_pos),
    .byte_val (wr_data[BYTE_W-1:0]),
    .c1_nxt   (c1_nxt),
    .c2_nxt   (c2_nxt),
    .o1_nxt   (o1_nxt),
    .o2_nxt   (o2_nxt)
  );

  assign commit1 = byte_last && (byte_blk == BLK_CH1);
  assign commit2 = byte_last && (byte_blk == BLK_CH2);

  coef_active_bank #(
    .N_COEF (N_COEF)
  ) u_bank (
    .clk     (clk),
    .rst_n   (srst_n),
    .commit1 (commit1),
    .commit2 (commit2),
    .c1_nxt  (c1_nxt),
    .c2_nxt  (c2_nxt),
    .o1_nxt  (o1_nxt),
    .o2_nxt  (o2_nxt),
    .c1_act  (ch1_coefs_o),
    .c2_act  (ch2_coefs_o),
    .o1_act  (ch1_ofs_o),
    .o2_act  (ch2_ofs_o),
    .pulse1  (ch1_commit_o),
    .pulse2  (ch2_commit_o)
  );

endmodule

// File: rtl/coef_loader_chk.sv
module coef_loader_chk #(
  parameter int unsigned       ADDR_W   = 16,
  parameter int unsigned       SET_W    = 48,
  parameter int unsigned       OFS_W    = 12,
  parameter logic [ADDR_W-1:0] CH1_ADDR = 16'h0001,
  parameter logic [ADDR_W-1:0] CH2_ADDR = 16'h0005
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [SET_W-1:0]  ch1_coefs_o,
  input logic [SET_W-1:0]  ch2_coefs_o,
  input logic [OFS_W-1:0]  ch1_ofs_o,
  input logic [OFS_W-1:0]  ch2_ofs_o,
  input logic              ch1_commit_o,
  input logic              ch2_commit_o
);

  // R6
  ch1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ch1_commit_o |-> ($stable(ch1_coefs_o) && $stable(ch1_ofs_o)));

  // R6
  ch2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ch2_commit_o |-> ($stable(ch2_coefs_o) && $stable(ch2_ofs_o)));

  // R7
  ch2_implies_ch1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch2_commit_o |-> ch1_commit_o);

  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch1_commit_o |=> !ch1_commit_o);

  // R9
  no_hit_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && ((wr_addr == CH1_ADDR) || (wr_addr == CH2_ADDR)))
      |=> (!ch1_commit_o && !ch2_commit_o));

endmodule

bind coef_block_loader coef_loader_chk #(
  .ADDR_W   (ADDR_W),
  .SET_W    (SET_W),
  .OFS_W    (coef_loader_pkg::OFS_W),
  .CH1_ADDR (CH1_ADDR),
  .CH2_ADDR (CH2_ADDR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .ch1_coefs_o  (ch1_coefs_o),
  .ch2_coefs_o  (ch2_coefs_o),
  .ch1_ofs_o    (ch1_ofs_o),
  .ch2_ofs_o    (ch2_ofs_o),
  .ch1_commit_o (ch1_commit_o),
  .ch2_commit_o (ch2_commit_o)
);

// File: tb/tb_coef_block_loader.sv
module tb_coef_block_loader;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam logic [15:0] A1 = 16'h0001;
  localparam logic [15:0] A2 = 16'h0005;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [15:0] wr_data;
  logic [47:0] ch1_coefs_o, ch2_coefs_o;
  logic [11:0] ch1_ofs_o, ch2_ofs_o;
  logic        ch1_commit_o, ch2_commit_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  coef_block_loader dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .ch1_coefs_o  (ch1_coefs_o),
    .ch2_coefs_o  (ch2_coefs_o),
    .ch1_ofs_o    (ch1_ofs_o),
    .ch2_ofs_o    (ch2_ofs_o),
    .ch1_commit_o (ch1_commit_o),
    .ch2_commit_o (ch2_commit_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Vector table: {address, data word, expected {ch2,ch1} pulse after the write}
  localparam logic [33:0] VEC [15] = '{
    {A1, 16'hFF15, 2'b00},   // R2: upper byte ignored
    {A1, 16'h0024, 2'b00},
    {A1, 16'h0033, 2'b00},
    {A1, 16'h0042, 2'b00},
    {A1, 16'h0051, 2'b00},
    {A1, 16'h0060, 2'b01},   // R3 completion
    {A2, 16'h0004, 2'b00},   // R5 offset bytes 04 40 00
    {A2, 16'h0040, 2'b00},
    {A2, 16'h0000, 2'b00},
    {A2, 16'h00A5, 2'b00},
    {A2, 16'h00B4, 2'b00},
    {A2, 16'h00C3, 2'b00},
    {A2, 16'h00D2, 2'b00},
    {A2, 16'h00E1, 2'b00},
    {A2, 16'h00F0, 2'b11}    // R4 completion, both pulses (R7)
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(posedge clk);
    #1;
  endtask

  // drive just after an edge, sample one unit after the capturing edge
  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic wr_chk(input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] exp_p, input string tag);
    wr(a, d);
    chk(tag, {62'd0, ch2_commit_o, ch1_commit_o}, {62'd0, exp_p});
  endtask

  // consecutive bytes first, first+1, ...; pulse expected only after the last
  task automatic wr_run(input logic [15:0] a, input logic [7:0] first, input int n,
                        input logic [1:0] last_p, input string tag);
    for (int i = 0; i < n; i++)
      wr_chk(a, {8'h00, first + 8'(i)}, (i == n-1) ? last_p : 2'b00, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) idle();
    rst_n = 1'b1;
    repeat (3) idle();
  endtask

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    repeat (2) idle();
    rst_n = 1'b1;
    repeat (3) idle();

    // R1: reset state
    chk("R1 ch1 coefs reset", {16'd0, ch1_coefs_o}, 64'd0);
    chk("R1 ch2 coefs reset", {16'd0, ch2_coefs_o}, 64'd0);
    chk("R1 offsets reset", {40'd0, ch1_ofs_o, ch2_ofs_o}, 64'd0);
    chk("R1 pulses low", {62'd0, ch2_commit_o, ch1_commit_o}, 64'd0);

    // table walk: pulses per write (R3 R4 R6 R7)
    for (int i = 0; i < 15; i++) begin
      wr_chk(VEC[i][33:18], VEC[i][17:2], VEC[i][1:0], "R7 table pulse");
      if (i == 4) chk("R6 ch1 unchanged before last byte", {16'd0, ch1_coefs_o}, 64'd0);
      if (i == 13) chk("R6 ch2 unchanged before last byte", {16'd0, ch2_coefs_o}, 64'd0);
    end
    chk("R3 R2 ch1 coefs", {16'd0, ch1_coefs_o}, {16'd0, 48'h15_24_33_42_51_60});
    chk("R4 ch2 coefs", {16'd0, ch2_coefs_o}, {16'd0, 48'hA5_B4_C3_D2_E1_F0});
    chk("R5 offsets 004/004", {40'd0, ch1_ofs_o, ch2_ofs_o}, {40'd0, 12'h004, 12'h004});

    // R5: distinct offsets split on the nibble boundary
    wr_chk(A2, 16'h003C, 2'b00, "R5 byte1");
    wr_chk(A2, 16'h009A, 2'b00, "R5 byte2");
    wr_chk(A2, 16'h007E, 2'b00, "R5 byte3");
    wr_run(A2, 8'h01, 5, 2'b00, "R5 coefs");
    chk("R6 offsets hold before last", {40'd0, ch1_ofs_o, ch2_ofs_o}, {40'd0, 12'h004, 12'h004});
    wr_chk(A2, 16'h0006, 2'b11, "R5 last");
    chk("R5 ch1 offset", {52'd0, ch1_ofs_o}, {52'd0, 12'hA3C});
    chk("R5 ch2 offset", {52'd0, ch2_ofs_o}, {52'd0, 12'h7E9});
    chk("R4 ch2 coefs second", {16'd0, ch2_coefs_o}, {16'd0, 48'h01_02_03_04_05_06});
    chk("R7 ch1 coefs untouched by ch2 block", {16'd0, ch1_coefs_o}, {16'd0, 48'h15_24_33_42_51_60});

    // R8: interrupted blocks
    wr_run(A1, 8'h77, 3, 2'b00, "R8 partial ch1");
    wr_run(A2, 8'h11, 2, 2'b00, "R8 partial ch2");
    chk("R8 ch1 unchanged", {16'd0, ch1_coefs_o}, {16'd0, 48'h15_24_33_42_51_60});
    wr_run(A1, 8'h81, 6, 2'b01, "R8 restarted ch1");
    chk("R8 ch1 new set", {16'd0, ch1_coefs_o}, {16'd0, 48'h81_82_83_84_85_86});
    chk("R8 ch2 unchanged", {16'd0, ch2_coefs_o}, {16'd0, 48'h01_02_03_04_05_06});
    wr_chk(A2, 16'h0055, 2'b00, "R8 ch2 restart b1");
    wr_chk(A2, 16'h0066, 2'b00, "R8 ch2 restart b2");
    wr_chk(A2, 16'h0077, 2'b00, "R8 ch2 restart b3");
    wr_run(A2, 8'hC0, 6, 2'b11, "R8 ch2 restart coefs");
    chk("R8 ch2 full set", {16'd0, ch2_coefs_o}, {16'd0, 48'hC0_C1_C2_C3_C4_C5});
    chk("R8 offsets", {40'd0, ch1_ofs_o, ch2_ofs_o}, {40'd0, 12'h655, 12'h776});

    // R9: idle cycles and foreign addresses inside a block
    wr_run(A1, 8'h90, 3, 2'b00, "R9 first half");
    wr_chk(16'h0003, 16'h0099, 2'b00, "R9 foreign addr");
    wr_chk(16'h0101, 16'h0098, 2'b00, "R9 foreign addr upper bits");
    idle();
    chk("R9 no pulse on idle", {62'd0, ch2_commit_o, ch1_commit_o}, 64'd0);
    chk("R9 ch1 unchanged", {16'd0, ch1_coefs_o}, {16'd0, 48'h81_82_83_84_85_86});
    wr_run(A1, 8'h93, 3, 2'b01, "R9 second half");
    chk("R9 ch1 set", {16'd0, ch1_coefs_o}, {16'd0, 48'h90_91_92_93_94_95});

    // R10: back-to-back blocks
    wr_run(A1, 8'hE0, 6, 2'b01, "R10 back to back");
    chk("R10 ch1 set", {16'd0, ch1_coefs_o}, {16'd0, 48'hE0_E1_E2_E3_E4_E5});

    // R1: reset in the middle of a block
    wr_run(A1, 8'h40, 3, 2'b00, "R1 pre-reset partial");
    do_reset();
    chk("R1 ch1 cleared", {16'd0, ch1_coefs_o}, 64'd0);
    chk("R1 offsets cleared", {40'd0, ch1_ofs_o, ch2_ofs_o}, 64'd0);
    wr_run(A1, 8'h0A, 6, 2'b01, "R1 fresh block after reset");
    chk("R1 ch1 after reset", {16'd0, ch1_coefs_o}, {16'd0, 48'h0A_0B_0C_0D_0E_0F});
    chk("R1 ch2 still zero", {16'd0, ch2_coefs_o}, 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule